// File: doc/BRIEF.md
# Atomic Compare-and-Swap Executor

This block sits in front of a small on-chip byte store and serves one atomic compare-and-swap request at a time. A request arrives as an address phase that carries a start address, a log2 beat-size field and a beat-count field. The write beats that follow are gathered into a single payload. The low half of that payload is the expected value and the high half is the replacement value.

Once the last beat is in, the block makes one pass over the store. It reads the target bytes and compares them with the expected value. It writes the replacement only on an exact match. In every case it returns the prior contents on the read-data channel, and it raises a write response alongside. Requests whose total size is not allowed, or whose address does not sit on a beat boundary, still have their beats drained. They are then answered with an error on both response channels and leave the store untouched.

While a request is in flight the block takes no new address phase. Only one request is ever outstanding.

Top module: `cas_exec`

## Requirements
- R1: The total size in bytes is (1 << aw_size) * (aw_len + 1). A request is legal only when that total is 2, 4, 8, 16 or 32 and one beat (1 << aw_size) fits the bus width of BUS_BYTES bytes. An illegal request returns b_resp = 2 and r_resp = 2, and the store is not modified.
- R2: A request whose aw_addr is not a multiple of (1 << aw_size) is rejected the same way: b_resp = 2, r_resp = 2, store unchanged.
- R3: Exactly aw_len + 1 write beats are accepted, whether or not the request is legal. Beat k carries its bytes in the low (1 << aw_size) byte lanes of w_data, and those bytes fill payload bytes k*(1 << aw_size) onward. The higher byte lanes are ignored.
- R4: The operand width is half the total size. Payload bytes below the operand width form the expected value. The next operand-width bytes form the replacement value.
- R5: On a legal request, the store bytes at aw_addr onward, wrapping modulo MEM_BYTES, are compared with the expected value over the operand width. They become the replacement value when every byte matches, and are left unchanged otherwise.
- R6: On a legal request r_resp = 0 and b_resp = 0, match or not. The low 8*operand bits of r_data hold the store contents from before the operation, and all higher bits are zero. On an error, r_data is zero.
- R7: b_valid and r_valid rise together in the second cycle after the cycle of the last beat handshake. Each holds its value steady until its own ready is seen, and the two handshakes may complete in either order. aw_ready stays low until both have completed.
- R8: After reset aw_ready = 1, w_ready = 0, b_valid = 0, r_valid = 0, and store byte i holds the value i.
- R9: w_ready is high only between the address handshake and the last beat, and is never high together with aw_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| aw_valid | input | 1 | Address phase valid |
| aw_ready | output | 1 | Address phase accepted (idle) |
| aw_addr | input | ADDR_W | Byte address of the target |
| aw_size | input | 3 | log2 of bytes per beat |
| aw_len | input | 8 | Beats minus one |
| w_valid | input | 1 | Write beat valid |
| w_ready | output | 1 | Write beat accepted |
| w_data | input | 8*BUS_BYTES | Write beat data, low lanes used |
| b_valid | output | 1 | Write response valid |
| b_ready | input | 1 | Write response taken |
| b_resp | output | 2 | 0 = okay, 2 = error |
| r_valid | output | 1 | Read data valid |
| r_ready | input | 1 | Read data taken |
| r_data | output | 8*OP_MAX | Prior store value, zero-extended |
| r_resp | output | 2 | 0 = okay, 2 = error |

## Verification
The main function is tried with several patterns. A matching expected value shows that the swap happens and that the old value comes back. Repeating the same request then gives a mismatch, which shows that the store stays put while its value is still returned. Operand widths of 1, 4, 8 and 16 bytes, spread over one, two and four beats with junk in the unused lanes, separate correct beat placement from lane mix-ups. A request that wraps past the top of the store checks the address modulo. Illegal totals, an oversized beat and a misaligned address each carry a payload that would match. A read-back request afterwards then shows whether the store was wrongly written.

// File: rtl/cas_pkg.sv
package cas_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_EXEC = 2'd2,
    ST_RESP = 2'd3
  } cas_state_t;

  localparam logic [1:0] RESP_OK  = 2'd0;
  localparam logic [1:0] RESP_ERR = 2'd2;

  // bytes carried by one beat
  function automatic logic [7:0] beat_bytes(input logic [2:0] sz);
    return 8'(9'd1 << sz);
  endfunction

  // bytes in the whole request
  function automatic logic [15:0] txn_bytes(input logic [2:0] sz, input logic [7:0] len);
    return 16'(beat_bytes(sz)) * (16'(len) + 16'd1);
  endfunction

  function automatic logic total_allowed(input logic [15:0] t);
    return (t == 16'd2) || (t == 16'd4) || (t == 16'd8) || (t == 16'd16) || (t == 16'd32);
  endfunction

endpackage

// File: rtl/cas_req_check.sv
module cas_req_check
  import cas_pkg::*;
#(
  parameter int BUS_BYTES = 8,
  parameter int ADDR_W    = 6
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        size,
  input  logic [7:0]        len,
  output logic [7:0]        bpb,
  output logic [7:0]        op_bytes,
  output logic              size_bad,
  output logic              align_bad
);
  localparam int SZ_MAX = $clog2(BUS_BYTES);

  logic [15:0] total;
  logic [15:0] addr_w;

  always_comb begin
    bpb       = beat_bytes(size);
    total     = txn_bytes(size, len);
    op_bytes  = total_allowed(total) ? 8'(total >> 1) : 8'd0;
    size_bad  = (32'(size) > SZ_MAX) || !total_allowed(total);
    addr_w    = 16'(addr);
    align_bad = |(addr_w & (16'(bpb) - 16'd1));
  end
endmodule

// File: rtl/cas_payload.sv
module cas_payload #(
  parameter int BUS_BYTES = 8,
  parameter int PAY_BYTES = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clear,
  input  logic                   beat_we,
  input  logic [7:0]             beat_idx,
  input  logic [7:0]             bpb,
  input  logic [8*BUS_BYTES-1:0] w_data,
  output logic [8*PAY_BYTES-1:0] payload
);
  logic [15:0] base;
  assign base = 16'(beat_idx) * 16'(bpb);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      payload <= '0;
    end else if (beat_we) begin
      for (int p = 0; p < PAY_BYTES; p++) begin
        for (int j = 0; j < BUS_BYTES; j++) begin
          if ((j < int'(bpb)) && (int'(base) + j == p))
            payload[p*8 +: 8] <= w_data[j*8 +: 8];
        end
      end
    end
  end
endmodule

// File: rtl/cas_mem.sv
module cas_mem #(
  parameter int MEM_BYTES = 64,
  parameter int OP_MAX    = 16,
  parameter int ADDR_W    = $clog2(MEM_BYTES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   base,
  input  logic [7:0]          op_bytes,
  input  logic [8*OP_MAX-1:0] cmp_val,
  input  logic [8*OP_MAX-1:0] swp_val,
  input  logic                exec_ok,
  output logic [8*OP_MAX-1:0] old_val,
  output logic                match,
  output logic                wrote
);
  logic [7:0] store [MEM_BYTES];
  logic [ADDR_W-1:0] idx [OP_MAX];

  for (genvar i = 0; i < OP_MAX; i++) begin : g_idx
    assign idx[i] = ADDR_W'(base + ADDR_W'(i));
  end

  always_comb begin
    match = 1'b1;
    for (int i = 0; i < OP_MAX; i++) begin
      if (i < int'(op_bytes)) begin
        old_val[i*8 +: 8] = store[idx[i]];
        if (store[idx[i]] != cmp_val[i*8 +: 8]) match = 1'b0;
      end else begin
        old_val[i*8 +: 8] = 8'd0;
      end
    end
  end

  assign wrote = exec_ok && match;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_BYTES; i++) store[i] <= 8'(i);
    end else if (wrote) begin
      for (int i = 0; i < OP_MAX; i++)
        if (i < int'(op_bytes)) store[idx[i]] <= swp_val[i*8 +: 8];
    end
  end
endmodule

// File: rtl/cas_exec.sv
module cas_exec
  import cas_pkg::*;
#(
  parameter int BUS_BYTES = 8,
  parameter int MEM_BYTES = 64,
  parameter int PAY_BYTES = 32,
  localparam int OP_MAX   = PAY_BYTES / 2,
  localparam int ADDR_W   = $clog2(MEM_BYTES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   aw_valid,
  output logic                   aw_ready,
  input  logic [ADDR_W-1:0]      aw_addr,
  input  logic [2:0]             aw_size,
  input  logic [7:0]             aw_len,
  input  logic                   w_valid,
  output logic                   w_ready,
  input  logic [8*BUS_BYTES-1:0] w_data,
  output logic                   b_valid,
  input  logic                   b_ready,
  output logic [1:0]             b_resp,
  output logic                   r_valid,
  input  logic                   r_ready,
  output logic [8*OP_MAX-1:0]    r_data,
  output logic [1:0]             r_resp
);
  cas_state_t state;
  logic [ADDR_W-1:0] req_addr;
  logic [2:0]        req_size;
  logic [7:0]        req_len;
  logic [7:0]        beat_cnt;
  logic              b_pend, r_pend;
  logic [1:0]        resp_q;
  logic [8*OP_MAX-1:0] r_data_q;

  // named events for the checker
  logic aw_fire, w_fire, last_beat, exec_fire, req_bad, mem_wrote;

  logic [7:0] bpb, op_bytes;
  logic size_bad, align_bad;
  logic [8*PAY_BYTES-1:0] payload, pay_shift;
  logic [8*OP_MAX-1:0] cmp_val, swp_val, old_val;
  logic mem_match;

  assign aw_ready  = (state == ST_IDLE);
  assign w_ready   = (state == ST_DATA);
  assign aw_fire   = aw_valid && aw_ready;
  assign w_fire    = w_valid && w_ready;
  assign last_beat = w_fire && (beat_cnt == req_len);
  assign exec_fire = (state == ST_EXEC);
  assign req_bad   = size_bad || align_bad;

  cas_req_check #(.BUS_BYTES(BUS_BYTES), .ADDR_W(ADDR_W)) u_chk_req (
    .addr(req_addr), .size(req_size), .len(req_len),
    .bpb(bpb), .op_bytes(op_bytes), .size_bad(size_bad), .align_bad(align_bad)
  );

  cas_payload #(.BUS_BYTES(BUS_BYTES), .PAY_BYTES(PAY_BYTES)) u_pay (
    .clk(clk), .rst_n(rst_n), .clear(aw_fire),
    .beat_we(w_fire && !size_bad), .beat_idx(beat_cnt), .bpb(bpb),
    .w_data(w_data), .payload(payload)
  );

  always_comb begin
    cmp_val   = payload[8*OP_MAX-1:0];
    pay_shift = payload >> (32'(op_bytes) * 8);
    swp_val   = pay_shift[8*OP_MAX-1:0];
  end

  cas_mem #(.MEM_BYTES(MEM_BYTES), .OP_MAX(OP_MAX), .ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .base(req_addr), .op_bytes(op_bytes),
    .cmp_val(cmp_val), .swp_val(swp_val), .exec_ok(exec_fire && !req_bad),
    .old_val(old_val), .match(mem_match), .wrote(mem_wrote)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      req_addr <= '0;
      req_size <= '0;
      req_len  <= '0;
      beat_cnt <= '0;
      b_pend   <= 1'b0;
      r_pend   <= 1'b0;
      resp_q   <= RESP_OK;
      r_data_q <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (aw_fire) begin
          req_addr <= aw_addr;
          req_size <= aw_size;
          req_len  <= aw_len;
          beat_cnt <= '0;
          state    <= ST_DATA;
        end
        ST_DATA: if (w_fire) begin
          if (last_beat) state <= ST_EXEC;
          else beat_cnt <= beat_cnt + 8'd1;
        end
        ST_EXEC: begin
          resp_q   <= req_bad ? RESP_ERR : RESP_OK;
          r_data_q <= req_bad ? '0 : old_val;
          b_pend   <= 1'b1;
          r_pend   <= 1'b1;
          state    <= ST_RESP;
        end
        ST_RESP: begin
          if (b_ready) b_pend <= 1'b0;
          if (r_ready) r_pend <= 1'b0;
          if ((!b_pend || b_ready) && (!r_pend || r_ready)) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign b_valid = b_pend;
  assign r_valid = r_pend;
  assign b_resp  = resp_q;
  assign r_resp  = resp_q;
  assign r_data  = r_data_q;
endmodule

// File: rtl/cas_exec_chk.sv
module cas_exec_chk #(
  parameter int DW = 128
) (
  input logic          clk,
  input logic          rst_n,
  input logic          aw_ready,
  input logic          w_ready,
  input logic          b_valid,
  input logic          b_ready,
  input logic [1:0]    b_resp,
  input logic          r_valid,
  input logic          r_ready,
  input logic [DW-1:0] r_data,
  input logic [1:0]    r_resp,
  input logic          exec_fire,
  input logic          req_bad,
  input logic          mem_wrote
);
  a_r9_ready_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(w_ready && aw_ready));

  a_r7_resp_after_exec: assert property (@(posedge clk) disable iff (!rst_n)
    exec_fire |=> (b_valid && r_valid));

  a_r7_b_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (b_valid && !b_ready) |=> (b_valid && $stable(b_resp)));

  a_r7_r_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (r_valid && !r_ready) |=> (r_valid && $stable(r_data) && $stable(r_resp)));

  a_r7_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (b_valid || r_valid) |-> !aw_ready);

  a_r6_resp_agree: assert property (@(posedge clk) disable iff (!rst_n)
    (b_valid && r_valid) |-> (b_resp == r_resp));

  // R1 / R2: an erroring request never reaches the store
  a_r2_no_write_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_fire && req_bad) |-> !mem_wrote);

  a_r6_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (r_valid && r_resp == 2'd2) |-> (r_data == '0));
endmodule

bind cas_exec cas_exec_chk #(.DW(8*OP_MAX)) u_cas_chk (
  .clk(clk), .rst_n(rst_n), .aw_ready(aw_ready), .w_ready(w_ready),
  .b_valid(b_valid), .b_ready(b_ready), .b_resp(b_resp),
  .r_valid(r_valid), .r_ready(r_ready), .r_data(r_data), .r_resp(r_resp),
  .exec_fire(exec_fire), .req_bad(req_bad), .mem_wrote(mem_wrote)
);

// File: tb/sim_cas_exec.sv
`timescale 1ns/1ps
module sim_cas_exec;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         aw_valid = 1'b0;
  logic         aw_ready;
  logic [5:0]   aw_addr = '0;
  logic [2:0]   aw_size = '0;
  logic [7:0]   aw_len = '0;
  logic         w_valid = 1'b0;
  logic         w_ready;
  logic [63:0]  w_data = '0;
  logic         b_valid;
  logic         b_ready = 1'b0;
  logic [1:0]   b_resp;
  logic         r_valid;
  logic         r_ready = 1'b0;
  logic [127:0] r_data;
  logic [1:0]   r_resp;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] mdl [64];

  always #5 clk = ~clk;

  cas_exec u0 (
    .clk(clk), .rst_n(rst_n),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_addr(aw_addr),
    .aw_size(aw_size), .aw_len(aw_len),
    .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data),
    .b_valid(b_valid), .b_ready(b_ready), .b_resp(b_resp),
    .r_valid(r_valid), .r_ready(r_ready), .r_data(r_data), .r_resp(r_resp)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [255:0] make_pl(input int op, input logic [127:0] c,
                                           input logic [127:0] s);
    logic [255:0] p;
    p = '0;
    for (int i = 0; i < op; i++) begin
      p[i*8 +: 8]      = c[i*8 +: 8];
      p[(op+i)*8 +: 8] = s[i*8 +: 8];
    end
    return p;
  endfunction

  function automatic logic [127:0] mdl_read(input int addr, input int op);
    logic [127:0] v;
    v = '0;
    for (int i = 0; i < op; i++) v[i*8 +: 8] = mdl[(addr + i) % 64];
    return v;
  endfunction

  // one full request; expected results from R1..R7
  task automatic run_cas(input string name, input int addr, input int size,
                         input int len, input logic [255:0] pl);
    int bpb, total, op, idx;
    bit ok, match;
    logic [127:0] exp_r;
    logic [1:0] exp_resp;
    bpb   = 1 << size;
    total = bpb * (len + 1);
    op    = total / 2;
    ok    = (size <= 3) && (total == 2 || total == 4 || total == 8 ||
             total == 16 || total == 32) && (addr % bpb == 0);
    if (ok) begin
      exp_r = mdl_read(addr, op);
      match = (exp_r == pl[127:0] || op == 16 && exp_r == pl[127:0]);
      match = 1'b1;
      for (int i = 0; i < op; i++) if (exp_r[i*8 +: 8] != pl[i*8 +: 8]) match = 1'b0;
      if (match) for (int i = 0; i < op; i++) mdl[(addr + i) % 64] = pl[(op+i)*8 +: 8];
      exp_resp = 2'd0;
    end else begin
      exp_r    = '0;
      exp_resp = 2'd2;
    end

    @(negedge clk);
    aw_valid = 1'b1; aw_addr = 6'(addr); aw_size = 3'(size); aw_len = 8'(len);
    while (!aw_ready) @(negedge clk);
    @(negedge clk);
    aw_valid = 1'b0;
    for (int k = 0; k <= len; k++) begin
      w_data = {8{8'hEE}};
      if (bpb <= 8)
        for (int j = 0; j < bpb; j++) begin
          idx = k * bpb + j;
          if (idx < 32) w_data[j*8 +: 8] = pl[idx*8 +: 8];
        end
      w_valid = 1'b1;
      chk(w_ready == 1'b1 && aw_ready == 1'b0, "R9", {name, " w_ready in data"},
          128'({w_ready, aw_ready}), 128'b10);
      @(negedge clk);
    end
    w_valid = 1'b0;
    chk(b_valid == 1'b0 && r_valid == 1'b0 && w_ready == 1'b0, "R7",
        {name, " no response one cycle after last beat"},
        128'({b_valid, r_valid, w_ready}), 128'd0);
    @(negedge clk);
    chk(b_valid && r_valid, "R7", {name, " both valid"}, 128'({b_valid, r_valid}), 128'b11);
    chk(b_resp == exp_resp, ok ? "R6" : "R1/R2", {name, " b_resp"}, 128'(b_resp), 128'(exp_resp));
    chk(r_resp == exp_resp, ok ? "R6" : "R1/R2", {name, " r_resp"}, 128'(r_resp), 128'(exp_resp));
    chk(r_data == exp_r, "R6", {name, " r_data"}, r_data, exp_r);
    @(negedge clk);
    chk(b_valid && r_valid && aw_ready == 1'b0 && r_data == exp_r, "R7",
        {name, " held while not ready"}, 128'({b_valid, r_valid, aw_ready}), 128'b110);
    b_ready = 1'b1;
    @(negedge clk);
    b_ready = 1'b0;
    chk(!b_valid && r_valid && !aw_ready, "R7", {name, " b alone taken"},
        128'({b_valid, r_valid, aw_ready}), 128'b010);
    r_ready = 1'b1;
    @(negedge clk);
    r_ready = 1'b0;
    chk(!r_valid && aw_ready, "R7", {name, " idle after both"},
        128'({r_valid, aw_ready}), 128'b01);
  endtask

  // read back 16 bytes with an expected value that cannot match (R5, R1/R2 no-write)
  task automatic readback(input string name, input int addr);
    run_cas({name, " readback"}, addr, 3, 3, make_pl(16, ~mdl_read(addr, 16), 128'hDEAD));
  endtask

  task automatic t_reset;
    chk(aw_ready && !w_ready && !b_valid && !r_valid, "R8", "reset outputs",
        128'({aw_ready, w_ready, b_valid, r_valid}), 128'b1000);
    readback("R8 init", 0);
    readback("R8 init hi", 48);
  endtask

  task automatic t_match_then_miss;
    // R4 R5 four-byte operands, two beats
    run_cas("R5 match 4B", 8, 2, 1, make_pl(4, mdl_read(8, 4), 128'hA1B2C3D4));
    run_cas("R5 repeat miss 4B", 8, 2, 1, make_pl(4, 128'h0B0A0908, 128'h11111111));
    readback("R5 after 4B", 0);
  endtask

  task automatic t_wide;
    // R3 four 8-byte beats, 16-byte operands
    run_cas("R3 miss 16B", 32, 3, 3, make_pl(16, 128'h1, 128'h55));
    run_cas("R3 match 16B", 32, 3, 3,
            make_pl(16, mdl_read(32, 16), 128'h0F0E0D0C_0B0A0908_07060504_03020100));
    run_cas("R3 match 8B one beat", 16, 3, 0, make_pl(4, mdl_read(16, 4), 128'hCAFEF00D));
    run_cas("R4 match 1B", 5, 0, 1, make_pl(1, mdl_read(5, 1), 128'h77));
    readback("R3 after wide", 16);
  endtask

  task automatic t_wrap;
    run_cas("R5 wrap", 60, 2, 3, make_pl(8, mdl_read(60, 8), 128'h8877665544332211));
    readback("R5 after wrap", 56);
    readback("R5 after wrap low", 0);
  endtask

  task automatic t_errors;
    run_cas("R1 total 6", 40, 1, 2, make_pl(3, mdl_read(40, 3), 128'hFFFFFF));
    run_cas("R1 beat wider than bus", 32, 4, 0, make_pl(8, mdl_read(32, 8), 128'h99));
    run_cas("R1 total 1", 41, 0, 0, make_pl(1, mdl_read(41, 1), 128'h99));
    run_cas("R2 misaligned", 6, 2, 1, make_pl(4, mdl_read(6, 4), 128'h12345678));
    readback("R1 R2 after errors", 32);
    readback("R2 after misaligned", 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 64; i++) mdl[i] = 8'(i);
    t_reset();
    t_match_then_miss();
    t_wide();
    t_wrap();
    t_errors();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule